// File: doc/BRIEF.md
# Serial Frame Aligner with Automatic Lock

This block sits behind a clock-recovery stage that already delivers one sampled bit per clock. It carries two slow, independent logic signals over one serial line. Each 12-bit frame holds one start bit, a 10-bit payload and one stop bit. The payload carries each signal twice, once as is and once inverted, so the line stays DC balanced. The aligner searches the bit stream for the frame boundary, declares lock, and then recovers the two signals from their non-inverted copies. It flags frames whose two copies disagree and watches the framing bits so that it can fall back to searching.

Alignment is found in one of two ways. The first is a single special pattern: six ones followed by six zeros. The second is a run of ordinary frames whose start/stop positions read 1 and 0 at the same bit offset. A candidate alignment must then be confirmed by the frame that follows it. While locked, the special pattern acts only as a keep-alive: it never counts as data.

Top module: `frame_sync_rx`

## Requirements
- R1: A frame is 12 bits in arrival order: a start bit of 1, payload bits p0..p9, then a stop bit of 0. Signal A is carried in p0 and signal B in p1. Their inverted copies are in p2 (A) and p3 (B). Bits p4..p9 are spare and are ignored.
- R2: While searching, a window equal to 111111000000 (oldest bit first) makes that offset the candidate. Two such frames back to back give lock one cycle after the last bit of the second frame.
- R3: While searching, a candidate is also declared when one offset shows start=1 and stop=0 in 4 consecutive frames.
- R4: The frame after a candidate must show good framing, or match the sync pattern, before lock rises. If it does not, the block returns to searching with lock low.
- R5: The block locks on a stream in which both signals stay high throughout, so every frame is identical.
- R6: While locked, a data frame with good framing and agreeing copies drives sig_out from p0/p1. The update happens one cycle after that frame's stop bit and not earlier.
- R7: sig_out stays 0 from reset until the first data frame accepted under lock, even if data frames arrive before that.
- R8: While locked, a data frame whose copies disagree raises frame_err for exactly one cycle. sig_out keeps its previous value.
- R9: While locked, a sync-pattern frame keeps lock, holds sig_out and raises no frame_err.
- R10: While locked, a frame with bad framing leaves sig_out unchanged. A good frame clears the count of consecutive bad frames.
- R11: A 4th consecutive frame with bad framing drops lock one cycle after its stop bit and returns the block to searching. sig_out keeps its value.
- R12: During and straight after reset, locked, frame_err and sig_out are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one sampled bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Recovered serial data bit |
| sig_out | output | N_CH (2) | Recovered signals; bit 0 is A, bit 1 is B |
| frame_err | output | 1 | One-cycle pulse for a locked data frame whose copies disagree |
| locked | output | 1 | Frame alignment is held |

## Verification
A sync frame fails the copy comparison, because its payload has ones in both the direct and the inverted positions. The sync keep-alive and the copy-error check therefore both qualify at the same frame boundary. The bench sends a sync frame right after a copy-error frame and after valid data while locked. It expects frame_err low and sig_out unchanged at the cycle after the stop bit. In the same way, a frame with bad framing but agreeing copies tests the framing counter against the data update at one boundary.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_VERIFY = 2'd1,
      ST_TRACK  = 2'd2
   } align_state_e;
endpackage

// File: rtl/fsrx_window.sv
module fsrx_window #(
   parameter int PAYLOAD_BITS = 10,
   parameter int N_CH         = 2,
   parameter bit CHECK_PAIRS  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ser_in,
   output logic            framing_ok,
   output logic            sync_hit,
   output logic [N_CH-1:0] true_bits,
   output logic            pair_ok
);
   localparam int FB   = PAYLOAD_BITS + 2;
   localparam int HALF = FB / 2;
   localparam logic [FB-1:0] SYNC_WORD = {{HALF{1'b1}}, {(FB-HALF){1'b0}}};

   if (2 * N_CH > PAYLOAD_BITS) begin : g_bad_width
      $error("payload too narrow for direct and inverted copies");
   end
   if (FB % 2 != 0) begin : g_bad_frame
      $error("frame length must be even for the sync pattern");
   end

   // oldest bit sits at the top: start at FB-1, stop at 0
   logic [FB-1:0] win_q;
   logic [N_CH-1:0] comp_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= {win_q[FB-2:0], ser_in};
   end

   assign framing_ok = win_q[FB-1] & ~win_q[0];
   assign sync_hit   = (win_q == SYNC_WORD);

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_field
      assign true_bits[ch] = win_q[FB-2-ch];
      assign comp_bits[ch] = win_q[FB-2-N_CH-ch];
   end

   if (CHECK_PAIRS) begin : g_pair_check
      assign pair_ok = &(true_bits ^ comp_bits);
   end else begin : g_pair_skip
      assign pair_ok = 1'b1;
   end
endmodule

// File: rtl/fsrx_hunter.sv
module fsrx_hunter #(
   parameter int FB         = 12,
   parameter int ACQ_FRAMES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic framing_ok,
   input  logic sync_hit,
   output logic cand
);
   localparam int PW = $clog2(FB);
   localparam int HW = $clog2(ACQ_FRAMES + 1);

   if (ACQ_FRAMES < 1) begin : g_bad_acq
      $error("ACQ_FRAMES must be at least 1");
   end

   logic [PW-1:0] ph_q;
   logic [FB-1:0] hit_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ph_q <= '0;
      else if (ph_q == PW'(FB - 1)) ph_q <= '0;
      else                          ph_q <= ph_q + 1'b1;
   end

   // one run counter per bit offset
   for (genvar g = 0; g < FB; g++) begin : g_phase
      logic [HW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                run_q <= '0;
         else if (!en)              run_q <= '0;
         else if (ph_q == PW'(g))   run_q <= framing_ok ? run_q + 1'b1 : '0;
      end
      assign hit_full[g] = (run_q == HW'(ACQ_FRAMES - 1));
   end

   assign cand = en & (sync_hit | (framing_ok & hit_full[ph_q]));

   a_r2_cand_single: assert property (@(posedge clk) disable iff (!rst_n)
      cand |=> !cand);
endmodule

// File: rtl/fsrx_lock.sv
module fsrx_lock
   import fsrx_pkg::*;
#(
   parameter int FB          = 12,
   parameter int LOSS_FRAMES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cand,
   input  logic framing_ok,
   input  logic sync_hit,
   output logic hunting,
   output logic locked,
   output logic take_frame
);
   localparam int PW = $clog2(FB);
   localparam int LW = $clog2(LOSS_FRAMES + 1);

   if (LOSS_FRAMES < 1) begin : g_bad_loss
      $error("LOSS_FRAMES must be at least 1");
   end

   align_state_e  st_q;
   logic [PW-1:0] fcnt_q;
   logic [LW-1:0] bad_q;
   logic          boundary;
   logic [PW-1:0] fcnt_nx;

   assign boundary = (st_q != ST_HUNT) && (fcnt_q == PW'(FB - 1));
   assign fcnt_nx  = (fcnt_q == PW'(FB - 1)) ? '0 : fcnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HUNT;
         fcnt_q <= '0;
         bad_q  <= '0;
      end else begin
         case (st_q)
            ST_HUNT: begin
               if (cand) begin
                  st_q   <= ST_VERIFY;
                  fcnt_q <= '0;
                  bad_q  <= '0;
               end
            end
            ST_VERIFY: begin
               fcnt_q <= fcnt_nx;
               if (boundary) st_q <= framing_ok ? ST_TRACK : ST_HUNT;
            end
            ST_TRACK: begin
               fcnt_q <= fcnt_nx;
               if (boundary) begin
                  if (framing_ok) begin
                     bad_q <= '0;
                  end else if (bad_q == LW'(LOSS_FRAMES - 1)) begin
                     st_q  <= ST_HUNT;
                     bad_q <= '0;
                  end else begin
                     bad_q <= bad_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_HUNT;
         endcase
      end
   end

   assign hunting    = (st_q == ST_HUNT);
   assign locked     = (st_q == ST_TRACK);
   assign take_frame = locked & boundary & framing_ok & ~sync_hit;

   // R4: lock only ever follows a verification frame
   a_r4_lock_after_verify: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(st_q == ST_VERIFY));
   // R11: losing lock always lands in search
   a_r11_drop_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> hunting);
endmodule

// File: rtl/frame_sync_rx.sv
module frame_sync_rx #(
   parameter int PAYLOAD_BITS = 10,
   parameter int N_CH         = 2,
   parameter int ACQ_FRAMES   = 4,
   parameter int LOSS_FRAMES  = 4,
   parameter bit CHECK_PAIRS  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ser_in,
   output logic [N_CH-1:0] sig_out,
   output logic            frame_err,
   output logic            locked
);
   localparam int FB = PAYLOAD_BITS + 2;

   logic            framing_ok, sync_hit, pair_ok, cand, hunting, take_frame;
   logic [N_CH-1:0] true_bits;
   logic [N_CH-1:0] sig_q;
   logic            err_q;

   fsrx_window #(.PAYLOAD_BITS(PAYLOAD_BITS), .N_CH(N_CH), .CHECK_PAIRS(CHECK_PAIRS)) u_window (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
      .framing_ok(framing_ok), .sync_hit(sync_hit),
      .true_bits(true_bits), .pair_ok(pair_ok)
   );

   fsrx_hunter #(.FB(FB), .ACQ_FRAMES(ACQ_FRAMES)) u_hunter (
      .clk(clk), .rst_n(rst_n), .en(hunting),
      .framing_ok(framing_ok), .sync_hit(sync_hit), .cand(cand)
   );

   fsrx_lock #(.FB(FB), .LOSS_FRAMES(LOSS_FRAMES)) u_lock (
      .clk(clk), .rst_n(rst_n), .cand(cand),
      .framing_ok(framing_ok), .sync_hit(sync_hit),
      .hunting(hunting), .locked(locked), .take_frame(take_frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (take_frame && pair_ok) sig_q <= true_bits;
         err_q <= take_frame & ~pair_ok;
      end
   end

   assign sig_out   = sig_q;
   assign frame_err = err_q;

   a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);
   a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> $stable(sig_q));
   a_r6_change_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_q != $past(sig_q)) |-> $past(locked));
endmodule

// File: tb/frame_sync_rx_tb.sv
module frame_sync_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b0;
   logic [1:0] sig;
   logic       ferr, lk;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;
   logic [3:0] snap0, snap1;

   always #2 clk = ~clk;

   frame_sync_rx u_dut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
      .sig_out(sig), .frame_err(ferr), .locked(lk)
   );

   // {kind[1:0], a, b, exp_lock, exp_a, exp_b, exp_err}
   // kind: 0 data, 1 sync, 2 bad stop bit, 3 inverted copy of A wrong
   localparam logic [7:0] VEC [15] = '{
      8'b01_00_0_00_0, 8'b01_00_1_00_0, 8'b00_10_1_10_0, 8'b00_01_1_01_0,
      8'b00_11_1_11_0, 8'b11_00_1_11_1, 8'b01_00_1_11_0, 8'b00_00_1_00_0,
      8'b10_11_1_00_0, 8'b10_11_1_00_0, 8'b00_10_1_10_0, 8'b10_01_1_10_0,
      8'b10_01_1_10_0, 8'b10_01_1_10_0, 8'b10_01_0_10_0
   };

   function automatic logic [11:0] mk(input logic [1:0] kind, input logic a, input logic b);
      logic [11:0] f;
      f = 12'b0;
      f[11] = 1'b1; f[10] = a; f[9] = b; f[8] = ~a; f[7] = ~b;
      case (kind)
         2'd1: f = 12'b111111000000;
         2'd2: f[0] = 1'b1;
         2'd3: f[8] = a;
         default: ;
      endcase
      return f;
   endfunction

   function automatic string tag_for(input int idx, input logic [1:0] kind, input logic lock);
      if (kind == 2'd3) return "R8";
      if (kind == 2'd2) return lock ? "R10" : "R11";
      if (kind == 2'd1) return (idx <= 1) ? "R2" : "R9";
      return "R6 R1";
   endfunction

   task automatic expect4(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b (lock,A,B,err)", req, act, exp);
      end
   endtask

   // sends f[11] first; snap0 = outputs before the previous frame's update,
   // snap1 = outputs after it
   task automatic send(input logic [11:0] f);
      for (int i = 11; i >= 0; i--) begin
         @(negedge clk);
         ser_in = f[i];
         if (i == 11) snap0 = {lk, sig[0], sig[1], ferr};
         if (i == 10) snap1 = {lk, sig[0], sig[1], ferr};
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ser_in = 1'b0;
      repeat (4) @(negedge clk);
      expect4("R12 in reset", {lk, sig[0], sig[1], ferr}, 4'b0000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      expect4("R12 after reset", {lk, sig[0], sig[1], ferr}, 4'b0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R12 watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();

      // table walk: results of vector idx-1 are seen while sending idx
      for (int idx = 0; idx <= 15; idx++) begin
         if (idx < 15) send(mk(VEC[idx][7:6], VEC[idx][5], VEC[idx][4]));
         else          send(mk(2'd0, 1'b1, 1'b1));
         if (idx > 0)
            expect4(tag_for(idx - 1, VEC[idx-1][7:6], VEC[idx-1][3]), snap1, VEC[idx-1][3:0]);
         if (idx == 3)
            expect4("R6 timing, no update before stop bit + 1", snap0, 4'b1000);
      end

      // R3 / R7: framing-based acquisition on varying data
      do_reset();
      send(mk(2'd0, 1'b0, 1'b0));
      send(mk(2'd0, 1'b1, 1'b0));
      send(mk(2'd0, 1'b0, 1'b1));
      send(mk(2'd0, 1'b1, 1'b1));
      send(mk(2'd0, 1'b0, 1'b0));
      expect4("R3 no lock yet after 4 frames", snap1, 4'b0000);
      send(mk(2'd0, 1'b1, 1'b0));
      expect4("R3 lock after confirming frame", {snap1[3], 3'b000}, 4'b1000);
      expect4("R7 outputs low until locked data", {1'b0, snap1[2:1], 1'b0}, 4'b0000);
      send(mk(2'd0, 1'b1, 1'b1));
      expect4("R6 first locked data", snap1, 4'b1100);

      // R4: bad confirmation frame returns to search
      do_reset();
      send(mk(2'd1, 1'b0, 1'b0));
      send(mk(2'd2, 1'b1, 1'b1));
      expect4("R4 candidate only", snap1, 4'b0000);
      send(mk(2'd1, 1'b0, 1'b0));
      expect4("R4 failed confirm stays unlocked", snap1, 4'b0000);
      send(mk(2'd1, 1'b0, 1'b0));
      expect4("R4 new candidate", snap1, 4'b0000);
      send(mk(2'd0, 1'b1, 1'b1));
      expect4("R4 confirmed lock", snap1, 4'b1000);
      send(mk(2'd0, 1'b0, 1'b0));
      expect4("R4 data after relock", snap1, 4'b1110);

      // R5: constant high signals, identical frames
      do_reset();
      for (int k = 0; k < 5; k++) send(mk(2'd0, 1'b1, 1'b1));
      send(mk(2'd0, 1'b1, 1'b1));
      expect4("R5 lock on constant stream", snap1, 4'b1000);
      send(mk(2'd0, 1'b1, 1'b1));
      expect4("R5 constant data recovered", snap1, 4'b1110);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule